// File: doc/BRIEF.md
# Flash Self-Write Controller with Holding Buffer

This block lets running code reprogram its own program memory, which is held here as a byte-wide register array. Code stages bytes in a holding buffer that is one write block wide. It then erases an erase block, which is made of several write blocks, or commits the buffer to one write block. Table reads return stored bytes. A second port, for an external programmer, reads and writes single bytes directly. A single protection input closes that external port and never affects internal access.

The flash rule the block enforces is that a write block may be committed only once after it has been erased. A repeated commit is refused with an error pulse. The holding buffer is never cleared after a commit, so a later commit writes the same staged bytes again unless code overwrites them. Erase and commit keep the block busy for a fixed number of cycles. The memory array is not reset, because it models non-volatile storage.

Top module: `fsw_ctrl`

## Requirements
- R1: A command with `cmd_op` = 0 (table write) stores `cmd_wdata` in the holding-buffer byte selected by the low log2(WB_BYTES) bits of `cmd_addr`. The upper address bits play no part in this.
- R2: A command with `cmd_op` = 3 (commit) to an armed write block copies all bytes of the holding buffer into that block, with buffer byte k going to block byte k. `busy` is then high for exactly BUSY_CYC cycles, starting the cycle after the command.
- R3: A commit to a write block that is not armed changes no memory and does not raise `busy`. `err` is high for exactly one cycle, the cycle after the command.
- R4: A command with `cmd_op` = 2 (erase) sets every byte of the erase block that `cmd_addr` selects to FFh and arms each write block inside it. Other erase blocks keep their contents. `busy` is high for BUSY_CYC cycles, as in R2.
- R5: A commit leaves the holding buffer unchanged. A later commit with no table writes in between stores the same bytes.
- R6: A command with `cmd_op` = 1 (table read) sets `rd_valid` high for one cycle, the cycle after the command, with `rd_data` holding the byte at `cmd_addr`.
- R7: While `ext_prot` is 1, an external read returns 0 with `ext_rvalid` and an external write is dropped. Internal table reads, table writes and commits still work.
- R8: While `ext_prot` is 0, an external write (`ext_req`=1, `ext_we`=1) stores `ext_wdata` at `ext_addr`. An external read (`ext_req`=1, `ext_we`=0) returns the byte at `ext_addr` on `ext_rdata`, with `ext_rvalid` high for one cycle, the cycle after the request.
- R9: While `busy` is high, every internal command (table write, table read, erase, commit) is ignored.
- R10: An external write is dropped if `busy` is high or if an erase or commit is accepted in the same cycle. An external read is always served, and returns the value stored before that cycle's updates.
- R11: After reset, `busy`, `err`, `rd_valid` and `ext_rvalid` are 0, every write block is disarmed, and every holding-buffer byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Internal command strobe |
| cmd_op | input | 2 | 0 table write, 1 table read, 2 erase, 3 commit |
| cmd_addr | input | AW | Byte address of the command |
| cmd_wdata | input | DW | Table-write data |
| rd_valid | output | 1 | Table-read result valid |
| rd_data | output | DW | Table-read result |
| ext_prot | input | 1 | Closes the external port when 1 |
| ext_req | input | 1 | External access strobe |
| ext_we | input | 1 | External write (1) or read (0) |
| ext_addr | input | AW | External byte address |
| ext_wdata | input | DW | External write data |
| ext_rvalid | output | 1 | External read result valid |
| ext_rdata | output | DW | External read result |
| busy | output | 1 | Erase or commit in progress |
| err | output | 1 | One-cycle pulse for a refused commit |

## Verification
Two functions can fall in the same cycle: an internal erase or commit, and an external access. The bench drives both strobes at the same clock edge. In one case it pairs an erase with an external write to an address outside the erased block, and later table reads must show that byte unchanged. In the other case it pairs an erase with an external read inside the erased block, and the read must return the byte stored before the erase, while later table reads show FFh.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [1:0] {
    OP_TWR   = 2'd0,
    OP_TRD   = 2'd1,
    OP_ERASE = 2'd2,
    OP_PROG  = 2'd3
  } fsw_op_e;
endpackage

// File: rtl/fsw_rst_sync.sv
module fsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/fsw_hold_buf.sv
module fsw_hold_buf #(
  parameter int WB_BYTES = 8,
  parameter int DW       = 8,
  localparam int WOFF    = $clog2(WB_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [WOFF-1:0]        wr_idx,
  input  logic [DW-1:0]          wr_data,
  output logic [WB_BYTES*DW-1:0] data_o
);
  logic [DW-1:0] buf_q [WB_BYTES];
  logic [DW-1:0] buf_d [WB_BYTES];

  always_comb begin
    for (int j = 0; j < WB_BYTES; j++) begin
      buf_d[j] = (wr_idx == WOFF'(j)) ? wr_data : buf_q[j];
      data_o[j*DW +: DW] = buf_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < WB_BYTES; j++) buf_q[j] <= '1;
    end else if (wr_en) begin
      buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/fsw_busy_timer.sv
module fsw_busy_timer #(
  parameter int BUSY_CYC = 4,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)              cnt_d = CW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fsw_store.sv
module fsw_store #(
  parameter int WB_BYTES  = 8,
  parameter int EB_WBLKS  = 4,
  parameter int MEM_BYTES = 128,
  parameter int DW        = 8,
  localparam int AW       = $clog2(MEM_BYTES),
  localparam int EB_BYTES = WB_BYTES * EB_WBLKS,
  localparam int NWB      = MEM_BYTES / WB_BYTES,
  localparam int NEB      = MEM_BYTES / EB_BYTES,
  localparam int WIW      = (NWB > 1) ? $clog2(NWB) : 1,
  localparam int EIW      = (NEB > 1) ? $clog2(NEB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   erase_en,
  input  logic [EIW-1:0]         erase_idx,
  input  logic                   prog_en,
  input  logic [WIW-1:0]         prog_idx,
  input  logic [WB_BYTES*DW-1:0] prog_data,
  input  logic                   byte_we,
  input  logic [AW-1:0]          byte_addr,
  input  logic [DW-1:0]          byte_wdata,
  input  logic [AW-1:0]          addr_a,
  output logic [DW-1:0]          data_a,
  input  logic [AW-1:0]          addr_b,
  output logic [DW-1:0]          data_b,
  output logic                   prog_armed
);
  logic [DW-1:0]  mem_q [MEM_BYTES];
  logic [DW-1:0]  mem_d [MEM_BYTES];
  logic [NWB-1:0] arm_q, arm_d;
  logic           mem_we;

  assign mem_we = erase_en | prog_en | byte_we;

  always_comb begin
    for (int i = 0; i < MEM_BYTES; i++) begin
      if (erase_en && erase_idx == EIW'(i / EB_BYTES))
        mem_d[i] = '1;
      else if (prog_en && prog_idx == WIW'(i / WB_BYTES))
        mem_d[i] = prog_data[(i % WB_BYTES)*DW +: DW];
      else if (byte_we && byte_addr == AW'(i))
        mem_d[i] = byte_wdata;
      else
        mem_d[i] = mem_q[i];
    end
    for (int w = 0; w < NWB; w++) begin
      if (erase_en && erase_idx == EIW'(w / EB_WBLKS)) arm_d[w] = 1'b1;
      else if (prog_en && prog_idx == WIW'(w))          arm_d[w] = 1'b0;
      else                                              arm_d[w] = arm_q[w];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  arm_q <= '0;
    else if (erase_en | prog_en) arm_q <= arm_d;
  end

  assign data_a     = mem_q[addr_a];
  assign data_b     = mem_q[addr_b];
  assign prog_armed = arm_q[prog_idx];
endmodule

// File: rtl/fsw_ctrl.sv
module fsw_ctrl #(
  parameter int WB_BYTES  = 8,
  parameter int EB_WBLKS  = 4,
  parameter int MEM_BYTES = 128,
  parameter int BUSY_CYC  = 4,
  parameter int DW        = 8,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ext_prot,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_rvalid,
  output logic [DW-1:0] ext_rdata,
  output logic          busy,
  output logic          err
);
  import fsw_pkg::*;

  localparam int WOFF = $clog2(WB_BYTES);
  localparam int EOFF = $clog2(WB_BYTES * EB_WBLKS);

  logic                   rst_q_n;
  fsw_op_e                op;
  logic                   accept, tw_en, rd_en, er_en, pg_req, pg_ok, pg_rej;
  logic                   start, ext_wr_ok, ext_rd_en, armed;
  logic [WB_BYTES*DW-1:0] buf_flat;
  logic [DW-1:0]          mem_a, mem_b;
  logic                   rd_valid_d, ext_rvalid_d, err_d;
  logic [DW-1:0]          ext_rdata_d;

  fsw_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // command decode
  always_comb begin
    op        = fsw_op_e'(cmd_op);
    accept    = cmd_valid && !busy;
    tw_en     = accept && (op == OP_TWR);
    rd_en     = accept && (op == OP_TRD);
    er_en     = accept && (op == OP_ERASE);
    pg_req    = accept && (op == OP_PROG);
    pg_ok     = pg_req && armed;
    pg_rej    = pg_req && !armed;
    start     = er_en || pg_ok;
    ext_wr_ok = ext_req && ext_we && !ext_prot && !busy && !start;
    ext_rd_en = ext_req && !ext_we;
  end

  fsw_hold_buf #(.WB_BYTES(WB_BYTES), .DW(DW)) i_buf (
    .clk(clk), .rst_n(rst_q_n), .wr_en(tw_en),
    .wr_idx(cmd_addr[WOFF-1:0]), .wr_data(cmd_wdata), .data_o(buf_flat)
  );

  fsw_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_tmr (
    .clk(clk), .rst_n(rst_q_n), .start(start), .busy(busy)
  );

  fsw_store #(.WB_BYTES(WB_BYTES), .EB_WBLKS(EB_WBLKS),
              .MEM_BYTES(MEM_BYTES), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_q_n),
    .erase_en(er_en), .erase_idx(cmd_addr[AW-1:EOFF]),
    .prog_en(pg_ok), .prog_idx(cmd_addr[AW-1:WOFF]), .prog_data(buf_flat),
    .byte_we(ext_wr_ok), .byte_addr(ext_addr), .byte_wdata(ext_wdata),
    .addr_a(cmd_addr), .data_a(mem_a),
    .addr_b(ext_addr), .data_b(mem_b),
    .prog_armed(armed)
  );

  // response next state
  always_comb begin
    rd_valid_d   = rd_en;
    ext_rvalid_d = ext_rd_en;
    err_d        = pg_rej;
    ext_rdata_d  = ext_prot ? '0 : mem_b;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_valid   <= 1'b0;
      ext_rvalid <= 1'b0;
      err        <= 1'b0;
      rd_data    <= '0;
      ext_rdata  <= '0;
    end else begin
      rd_valid   <= rd_valid_d;
      ext_rvalid <= ext_rvalid_d;
      err        <= err_d;
      if (rd_en)     rd_data   <= mem_a;
      if (ext_rd_en) ext_rdata <= ext_rdata_d;
    end
  end
endmodule

// File: rtl/fsw_ctrl_chk.sv
module fsw_ctrl_chk #(
  parameter int BUSY_CYC = 4,
  parameter int AW       = 7,
  parameter int DW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          rd_valid,
  input logic          ext_prot,
  input logic          ext_rvalid,
  input logic [DW-1:0] ext_rdata,
  input logic          busy,
  input logic          err
);
  localparam int RW = $clog2(BUSY_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < RW'(BUSY_CYC));
  a_r2_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == RW'(BUSY_CYC));
  a_r3_err_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  a_r3_err_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_op == 2'd3));
  a_r6_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd1) |=> rd_valid);
  a_r7_prot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rvalid && $past(ext_prot)) |-> ext_rdata == '0);
  a_r9_no_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(busy));
endmodule

bind fsw_ctrl fsw_ctrl_chk #(.BUSY_CYC(BUSY_CYC), .AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_valid(rd_valid), .ext_prot(ext_prot), .ext_rvalid(ext_rvalid),
  .ext_rdata(ext_rdata), .busy(busy), .err(err)
);

// File: tb/test_fsw_ctrl.sv
module test_fsw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       ext_prot, ext_req, ext_we;
  logic [6:0] ext_addr;
  logic [7:0] ext_wdata;
  logic       ext_rvalid;
  logic [7:0] ext_rdata;
  logic       busy, err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] mem_m [128];
  bit         arm_m [16];
  logic [7:0] buf_m [8];

  always #4 clk = ~clk;

  fsw_ctrl i_fsw_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ext_prot(ext_prot), .ext_req(ext_req),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata), .busy(busy), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cyc_cmd(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic tw(input logic [6:0] a, input logic [7:0] d);
    wait_idle();
    cyc_cmd(2'd0, a, d);
    buf_m[a[2:0]] = d;
  endtask

  task automatic iread_chk(input logic [6:0] a, input string req);
    wait_idle();
    cyc_cmd(2'd1, a, 8'h00);
    check(rd_valid === 1'b1, req, "rd_valid", int'(rd_valid), 1);
    check(rd_data === mem_m[a], req, $sformatf("rd_data @%0h", a),
          int'(rd_data), int'(mem_m[a]));
  endtask

  task automatic blk_chk(input int base, input int n, input string req);
    for (int i = 0; i < n; i++) iread_chk(7'(base + i), req);
  endtask

  task automatic do_erase(input logic [6:0] a, input string req);
    int n;
    wait_idle();
    cyc_cmd(2'd2, a, 8'h00);
    for (int i = 0; i < 32; i++) mem_m[{a[6:5], 5'(i)}] = 8'hFF;
    for (int w = 0; w < 4; w++) arm_m[{a[6:5], 2'(w)}] = 1'b1;
    count_busy(n);
    check(n == 4, req, "erase busy cycles", n, 4);
  endtask

  task automatic do_prog(input logic [6:0] a, input string req);
    int n;
    bit exp_err;
    wait_idle();
    exp_err = !arm_m[a[6:3]];
    cyc_cmd(2'd3, a, 8'h00);
    check(err === exp_err, req, "err after commit", int'(err), int'(exp_err));
    count_busy(n);
    check(n == (exp_err ? 0 : 4), req, "commit busy cycles", n, exp_err ? 0 : 4);
    if (!exp_err) begin
      for (int i = 0; i < 8; i++) mem_m[{a[6:3], 3'(i)}] = buf_m[i];
      arm_m[a[6:3]] = 1'b0;
    end
    if (exp_err) begin
      @(negedge clk);
      check(err === 1'b0, req, "err single cycle", int'(err), 0);
    end
  endtask

  task automatic xwrite(input logic [6:0] a, input logic [7:0] d);
    ext_req = 1'b1; ext_we = 1'b1; ext_addr = a; ext_wdata = d;
    @(posedge clk); @(negedge clk);
    ext_req = 1'b0; ext_we = 1'b0;
  endtask

  task automatic xread_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
    ext_req = 1'b1; ext_we = 1'b0; ext_addr = a;
    @(posedge clk); @(negedge clk);
    ext_req = 1'b0;
    check(ext_rvalid === 1'b1, req, "ext_rvalid", int'(ext_rvalid), 1);
    check(ext_rdata === exp, req, "ext_rdata", int'(ext_rdata), int'(exp));
  endtask

  // R11: reset state, disarmed blocks
  task automatic t_reset();
    check(busy === 1'b0, "R11", "busy", int'(busy), 0);
    check(err === 1'b0, "R11", "err", int'(err), 0);
    check(rd_valid === 1'b0, "R11", "rd_valid", int'(rd_valid), 0);
    check(ext_rvalid === 1'b0, "R11", "ext_rvalid", int'(ext_rvalid), 0);
    do_prog(7'h00, "R11");
  endtask

  // R4: erase whole array, R11: buffer FFh after reset
  task automatic t_erase_all();
    for (int e = 0; e < 4; e++) do_erase(7'(e * 32), "R4");
    blk_chk(0, 8, "R4");
    do_prog(7'h38, "R11");
    blk_chk(8'h38, 8, "R11");
  endtask

  // R1, R2: stage with high address bits set, commit, read back
  task automatic t_program();
    for (int i = 0; i < 8; i++) tw(7'(8'h40 + i), 8'(8'hA0 + i));
    do_prog(7'h08, "R2");
    blk_chk(8, 8, "R1");
    blk_chk(0, 8, "R2");
  endtask

  // R3: second commit refused
  task automatic t_double();
    tw(7'h01, 8'h55);
    do_prog(7'h09, "R3");
    blk_chk(8, 8, "R3");
  endtask

  // R5: buffer retained
  task automatic t_retain();
    do_prog(7'h10, "R5");
    blk_chk(16, 8, "R5");
    tw(7'h03, 8'h3C);
    do_prog(7'h18, "R1");
    blk_chk(24, 8, "R5");
  endtask

  // R4: re-arm, neighbour erase block untouched
  task automatic t_rearm();
    xwrite(7'd40, 8'h5A);
    mem_m[40] = 8'h5A;
    do_erase(7'h00, "R4");
    blk_chk(8, 24, "R4");
    do_prog(7'h08, "R4");
    blk_chk(8, 8, "R4");
    iread_chk(7'd40, "R4");
  endtask

  // R9: commands ignored while busy
  task automatic t_busy_ignore();
    wait_idle();
    cyc_cmd(2'd3, 7'h20, 8'h00);
    for (int i = 0; i < 8; i++) mem_m[32 + i] = buf_m[i];
    arm_m[4] = 1'b0;
    check(busy === 1'b1, "R9", "busy after commit", int'(busy), 1);
    cyc_cmd(2'd0, 7'h00, 8'h11);
    cyc_cmd(2'd1, 7'h20, 8'h00);
    check(rd_valid === 1'b0, "R9", "read while busy", int'(rd_valid), 0);
    cyc_cmd(2'd2, 7'h08, 8'h00);
    wait_idle();
    blk_chk(8, 8, "R9");
    blk_chk(32, 8, "R9");
    do_prog(7'h28, "R9");
    blk_chk(40, 8, "R9");
  endtask

  // R7, R8: protection
  task automatic t_prot();
    ext_prot = 1'b1;
    xread_chk(7'd8, 8'h00, "R7");
    xwrite(7'd8, 8'h77);
    iread_chk(7'd8, "R7");
    tw(7'h02, 8'hC3);
    do_prog(7'h40, "R7");
    blk_chk(64, 8, "R7");
    ext_prot = 1'b0;
    xread_chk(7'd8, mem_m[8], "R8");
    xwrite(7'd72, 8'h3C);
    mem_m[72] = 8'h3C;
    xread_chk(7'd72, 8'h3C, "R8");
  endtask

  // R10: collisions with erase and busy
  task automatic t_collide();
    logic [7:0] old;
    wait_idle();
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 7'h60;
    ext_req = 1'b1; ext_we = 1'b1; ext_addr = 7'd10; ext_wdata = 8'h99;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; ext_req = 1'b0; ext_we = 1'b0;
    for (int i = 0; i < 32; i++) mem_m[96 + i] = 8'hFF;
    for (int w = 12; w < 16; w++) arm_m[w] = 1'b1;
    xwrite(7'd12, 8'h98);
    wait_idle();
    iread_chk(7'd10, "R10");
    iread_chk(7'd12, "R10");
    old = mem_m[33];
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 7'h20;
    ext_req = 1'b1; ext_we = 1'b0; ext_addr = 7'd33;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; ext_req = 1'b0;
    check(ext_rdata === old, "R10", "ext read during erase", int'(ext_rdata), int'(old));
    for (int i = 0; i < 32; i++) mem_m[32 + i] = 8'hFF;
    for (int w = 4; w < 8; w++) arm_m[w] = 1'b1;
    iread_chk(7'd33, "R10");
    blk_chk(96, 4, "R10");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_wdata = '0;
    ext_prot = 1'b0; ext_req = 1'b0; ext_we = 1'b0; ext_addr = '0; ext_wdata = '0;
    for (int i = 0; i < 16; i++) arm_m[i] = 1'b0;
    for (int i = 0; i < 8; i++) buf_m[i] = 8'hFF;
    for (int i = 0; i < 128; i++) mem_m[i] = 8'hxx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_erase_all();
    t_program();
    t_double();
    t_retain();
    t_rearm();
    t_busy_ignore();
    t_prot();
    t_collide();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule